// File: doc/BRIEF.md
# Set/Clear Mailbox Register Bank

This block holds a bank of 32-bit mailboxes for signalling between processor cores. By default there are sixteen, four owned by each of four cores: mailbox n belongs to core n/4 and sits at position n%4 within that core. Software reaches the mailboxes over a simple 32-bit register bus. Each mailbox appears at two addresses. A write to the set alias ORs the written word into the mailbox. A write to the clear alias removes every bit that is one in the written word. Reads return the contents only through the clear alias. Reads of the set alias always return zero.

Each mailbox drives a flag that is high whenever its contents are non-zero. The flags are also grouped per core into an eight-bit source byte, ready for a downstream interrupt router. Enabling and routing those interrupts is left to the router.

Top module: `mbx_bank`

## Requirements
- R1: After synchronous reset every mailbox holds zero, every pending flag is low and every source byte is zero.
- R2: A write to byte offset 0x80 + 4·n ORs the write data into mailbox n.
- R3: A write to byte offset 0xC0 + 4·n clears each bit of mailbox n that is one in the write data and leaves the other bits unchanged.
- R4: A read at 0xC0 + 4·n returns the contents of mailbox n. A read anywhere in 0x80–0xBF returns zero.
- R5: `pend_o[n]` is high exactly when mailbox n is non-zero. It reflects a write in the cycle after that write is accepted.
- R6: In `core_src_o`, byte i belongs to core i. Bit 4+j of that byte equals the pending flag of mailbox 4·i+j, and bits 0–3 of each byte are always zero.
- R7: An access whose address is not word aligned (addr[1:0] ≠ 0), or whose address lies below 0x80, has no effect on any mailbox, and a read of such an address returns zero.
- R8: Every read request gives exactly one `rsp_valid_o` pulse, on the cycle after the request. Writes give no response.
- R9: A write to one mailbox leaves every other mailbox unchanged. When no write is made, every mailbox holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Bus request strobe, one access per cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Byte offset of the access |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after the read request |
| rsp_rdata_o | output | 32 | Read data |
| pend_o | output | 16 | Per-mailbox non-zero flag |
| core_src_o | output | 32 | Per-core source byte, mailbox flags in bits 4–7 |

## Verification
The assertions assume a single-ported bus: at most one access per cycle, and the address and data are stable and known while the strobe is high. They also assume that reset is held for at least one clock edge before any request. The bench drives one access at a time on the falling edge and keeps every request strobe low during reset. It uses only full-word aligned offsets, except for the deliberate misaligned and out-of-window accesses that check R7.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    MB_OP_NONE = 2'd0,
    MB_OP_SET  = 2'd1,
    MB_OP_CLR  = 2'd2
  } mb_op_e;

  // Window codes held in the address bits above the mailbox index.
  localparam logic [1:0] WIN_SET = 2'b10;
  localparam logic [1:0] WIN_CLR = 2'b11;
endpackage

// File: rtl/mbx_dec.sv
module mbx_dec
  import mbx_pkg::*;
#(
  parameter int IDX_W  = 4,
  localparam int ADDR_W = IDX_W + 4
) (
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output mb_op_e            op_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              rd_hit_o
);
  logic       aligned;
  logic [1:0] win;

  assign aligned = (req_addr_i[1:0] == 2'b00);
  assign win     = req_addr_i[ADDR_W-1 -: 2];
  assign idx_o   = req_addr_i[IDX_W+1:2];

  always_comb begin
    op_o = MB_OP_NONE;
    if (req_valid_i && req_write_i && aligned) begin
      if (win == WIN_SET)      op_o = MB_OP_SET;
      else if (win == WIN_CLR) op_o = MB_OP_CLR;
    end
  end

  assign rd_hit_o = req_valid_i && !req_write_i && aligned && (win == WIN_CLR);
endmodule

// File: rtl/mbx_cell.sv
module mbx_cell
  import mbx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  mb_op_e            op_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] val_o,
  output logic              nz_o
);
  logic [DATA_W-1:0] val_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= '0;
    end else begin
      unique case (op_i)
        MB_OP_SET: val_q <= val_q | wdata_i;
        MB_OP_CLR: val_q <= val_q & ~wdata_i;
        default:   val_q <= val_q;
      endcase
    end
  end

  assign val_o = val_q;
  assign nz_o  = |val_q;

  p_reset_zero_r1: assert property (@(posedge clk) rst |=> (val_o == '0 && !nz_o));
  p_set_or_r2: assert property (@(posedge clk) disable iff (rst)
    (op_i == MB_OP_SET) |=> (val_o == ($past(val_o) | $past(wdata_i))));
  p_clr_mask_r3: assert property (@(posedge clk) disable iff (rst)
    (op_i == MB_OP_CLR) |=> (val_o == ($past(val_o) & ~$past(wdata_i))));
  p_set_pend_r5: assert property (@(posedge clk) disable iff (rst)
    (op_i == MB_OP_SET && wdata_i != '0) |=> nz_o);
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (op_i == MB_OP_NONE) |=> $stable(val_o));
endmodule

// File: rtl/mbx_bank.sv
module mbx_bank
  import mbx_pkg::*;
#(
  parameter int NUM_CORES    = 4,
  parameter int BOX_PER_CORE = 4,
  parameter int DATA_W       = 32,
  localparam int NUM_BOX = NUM_CORES * BOX_PER_CORE,
  localparam int IDX_W   = $clog2(NUM_BOX),
  localparam int ADDR_W  = IDX_W + 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid_i,
  input  logic                   req_write_i,
  input  logic [ADDR_W-1:0]      req_addr_i,
  input  logic [DATA_W-1:0]      req_wdata_i,
  output logic                   rsp_valid_o,
  output logic [DATA_W-1:0]      rsp_rdata_o,
  output logic [NUM_BOX-1:0]     pend_o,
  output logic [NUM_CORES*8-1:0] core_src_o
);
  mb_op_e            dec_op;
  logic [IDX_W-1:0]  dec_idx;
  logic              dec_rd_hit;
  logic [DATA_W-1:0] box_val [NUM_BOX];
  logic [NUM_BOX-1:0] box_nz;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q;

  mbx_dec #(.IDX_W(IDX_W)) u_dec (
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .op_o        (dec_op),
    .idx_o       (dec_idx),
    .rd_hit_o    (dec_rd_hit)
  );

  for (genvar n = 0; n < NUM_BOX; n++) begin : g_box
    mb_op_e cell_op;
    assign cell_op = (dec_idx == IDX_W'(n)) ? dec_op : MB_OP_NONE;
    mbx_cell #(.DATA_W(DATA_W)) u_cell (
      .clk     (clk),
      .rst     (rst),
      .op_i    (cell_op),
      .wdata_i (req_wdata_i),
      .val_o   (box_val[n]),
      .nz_o    (box_nz[n])
    );
  end

  assign pend_o = box_nz;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [7:0] src;
    always_comb begin
      src = '0;
      for (int j = 0; j < BOX_PER_CORE && j < 4; j++) begin
        src[4+j] = box_nz[c*BOX_PER_CORE + j];
      end
    end
    assign core_src_o[c*8 +: 8] = src;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= req_valid_i && !req_write_i;
      rsp_rdata_q <= dec_rd_hit ? box_val[dec_idx] : '0;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;

  p_rsp_after_read_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_o |-> $past(req_valid_i && !req_write_i));
  p_read_gets_rsp_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && !req_write_i) |=> rsp_valid_o);
  p_setwin_reads_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && !req_write_i && req_addr_i[ADDR_W-1 -: 2] == WIN_SET) |=> (rsp_rdata_o == '0));
  p_low_addr_no_change_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_addr_i[ADDR_W-1] == 1'b0) |=> $stable(pend_o));
endmodule

// File: tb/tb_mbx_bank.sv
module tb_mbx_bank;
  localparam int NB = 16;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [15:0] pend;
  logic [31:0] core_src;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] model [NB];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  mbx_bank dut (
    .clk(clk), .rst(rst),
    .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .pend_o(pend), .core_src_o(core_src)
  );

  // Monitor: pops expected read data as responses appear.
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R8 unexpected response got %h expected none", rsp_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rsp_rdata !== e) begin
          errors++;
          $display("FAIL %s read data got %h expected %h", t, rsp_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    if (a[1:0] == 2'b00 && a[7:6] == 2'b10) model[a[5:2]] = model[a[5:2]] | d;
    if (a[1:0] == 2'b00 && a[7:6] == 2'b11) model[a[5:2]] = model[a[5:2]] & ~d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input string t);
    logic [31:0] e;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    e = (a[1:0] == 2'b00 && a[7:6] == 2'b11) ? model[a[5:2]] : 32'h0;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic chk_flags(input string t);
    logic [15:0] ep;
    logic [31:0] es;
    for (int n = 0; n < NB; n++) ep[n] = (model[n] != 0);
    es = '0;
    for (int c = 0; c < 4; c++)
      for (int j = 0; j < 4; j++) es[c*8+4+j] = ep[c*4+j];
    checks++;
    if (pend !== ep) begin
      errors++;
      $display("FAIL %s R5 pend got %h expected %h", t, pend, ep);
    end
    checks++;
    if (core_src !== es) begin
      errors++;
      $display("FAIL %s R6 core_src got %h expected %h", t, core_src, es);
    end
  endtask

  task automatic read_all(input string t);
    for (int n = 0; n < NB; n++) rd(8'hC0 + 8'(4*n), t);
  endtask

  initial begin
    for (int n = 0; n < NB; n++) model[n] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_flags("R1 reset");
    read_all("R1 reset");
    // R2 set accumulates
    wr(8'h8C, 32'h0000_000F); chk_flags("R2");
    wr(8'h8C, 32'h0000_00F0); chk_flags("R2");
    rd(8'hCC, "R2 or");
    // R4 set alias reads zero
    rd(8'h8C, "R4 set window");
    rd(8'hBC, "R4 set window top");
    // R3 clear
    wr(8'hCC, 32'h0000_000F); chk_flags("R3");
    rd(8'hCC, "R3 clear");
    wr(8'hCC, 32'hFFFF_FFFF); chk_flags("R3 R5 to zero");
    rd(8'hCC, "R3 empty");
    // R6 one mailbox per core position, patterns per box
    for (int n = 0; n < NB; n++) begin
      wr(8'h80 + 8'(4*n), 32'h1 << n);
      chk_flags("R6 walk");
    end
    wr(8'hBC, 32'hA5A5_0000); chk_flags("R9");
    read_all("R9 isolation");
    // R7 misaligned and low addresses ignored
    wr(8'h81, 32'hFFFF_FFFF); chk_flags("R7 misaligned set");
    wr(8'hC2, 32'hFFFF_FFFF); chk_flags("R7 misaligned clr");
    wr(8'h40, 32'hFFFF_FFFF); chk_flags("R7 low addr");
    rd(8'h40, "R7 low read");
    rd(8'hC1, "R7 misaligned read");
    read_all("R7 after ignored");
    // clear everything, flags fall
    for (int n = 0; n < NB; n++) wr(8'hC0 + 8'(4*n), 32'hFFFF_FFFF);
    chk_flags("R5 all clear");
    // R1 reset mid-run
    wr(8'h84, 32'h1234_5678);
    @(negedge clk); rst = 1'b1;
    for (int n = 0; n < NB; n++) model[n] = '0;
    @(negedge clk); rst = 1'b0;
    chk_flags("R1 reset again");
    rd(8'hC4, "R1 reset again");
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R8 missing responses got %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule